// File: doc/BRIEF.md
# Maskable Interrupt Controller with Software Injection

This block gathers a set of interrupt request lines into one request toward a processor. A rising edge on a line latches that line into a pending register. Software can also raise a line on its own through a force register, and that line stays active for as long as its force bit is set. A mask register chooses which lines may reach the processor. The output gives a single request flag and the number of the highest-numbered line that is active and enabled.

Software reaches the block through a simple register port with byte offsets and combinational read data. Writing the clear register with a 1 in a bit drops that line's pending state. Writing the force register loads the whole word. The processor can also acknowledge one line by number, which removes the source that is keeping that line active. Line 0 is reserved and never becomes active.

Top module: `irq_force_ctl`

## Requirements
- R1: After reset the pending, force and mask registers read 0, irq_req is 0 and irq_id is 0.
- R2: A 0-to-1 transition on irq_in[N] (N from 1 to 15) sets pending bit N one clock later. A line that stays high does not set the bit again. Line 0 never becomes pending.
- R3: A write to offset 0x0C clears each pending bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R4: A write to offset 0x08 replaces the whole force register, so a 0 in bit N removes an earlier force on line N. Bit 0 always stores 0. A forced line counts as active while its force bit is set.
- R5: The mask register at offset 0x40 enables line N when bit N is 1 and always stores 0 in bit 0. A disabled line is kept out of irq_req and irq_id, but its pending bit stays set.
- R6: irq_req is 1 exactly when some line is both active (pending or forced) and enabled. irq_id is the highest such line number, or 0 when there is none.
- R7: An acknowledge (ack_valid with ack_id = N) clears force bit N if that bit is set, and otherwise clears pending bit N.
- R8: Reads return pending at 0x04, force at 0x08 and mask at 0x40, each in bits 15:0. Every other offset, including 0x0C, reads 0.
- R9: When a rising edge and a clear of the same pending bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | 16 | Interrupt request lines; bit 0 is ignored |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ack_valid | input | 1 | Acknowledge strobe, one cycle |
| ack_id | input | 4 | Line number being acknowledged |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | 4 | Highest-numbered active and enabled line |

## Verification
Each line is driven with an edge on its own, then held high after a clear, to separate edge capture from level capture. Priority is checked by forcing every pair of lines and then rewriting the force register to a single line, which catches encoders that pick the lowest line and force writes that merge bits instead of replacing them. A mask sweep over a full pending set moves the enabled window one line at a time, and a partial clear pattern shows that 0 bits have no effect. Acknowledges are tried on a pending-only line, a forced-only line and a line that is both, and an edge is made to coincide with a clear to show that the set takes priority.

// File: rtl/ictl_pkg.sv
`timescale 1ns/1ps
package ictl_pkg;
  localparam int unsigned OFS_PEND  = 'h04;
  localparam int unsigned OFS_FORCE = 'h08;
  localparam int unsigned OFS_CLEAR = 'h0C;
  localparam int unsigned OFS_MASK  = 'h40;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_PEND,
    RSEL_FORCE,
    RSEL_CLEAR,
    RSEL_MASK
  } rsel_e;
endpackage

// File: rtl/ictl_edge.sv
`timescale 1ns/1ps
module ictl_edge #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lines_i;
  end

  assign rise_o = lines_i & ~prev_q;
endmodule

// File: rtl/ictl_prio.sv
`timescale 1ns/1ps
module ictl_prio #(
  parameter int N    = 16,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    active_i,
  output logic            req_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = 1; i < N; i++) begin
      if (active_i[i]) id_o = ID_W'(i);
    end
  end

  assign req_o = |active_i[N-1:1];
endmodule

// File: rtl/ictl_regs.sv
`timescale 1ns/1ps
module ictl_regs
  import ictl_pkg::*;
#(
  parameter int N      = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int ID_W   = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [N-1:0]      rise_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_valid_i,
  input  logic [ID_W-1:0]   ack_id_i,
  output logic [N-1:0]      pend_o,
  output logic [N-1:0]      force_o,
  output logic [N-1:0]      mask_o
);
  localparam logic [N-1:0] LINE_MASK = {{(N-1){1'b1}}, 1'b0};

  rsel_e        rsel;
  logic [N-1:0] wdata_n;
  logic [N-1:0] set_vec, clr_wr_vec, ack_vec, ack_to_pend, ack_to_force;
  logic [N-1:0] pend_q, pend_d, force_q, force_d, mask_q, mask_d;
  logic         pend_en, force_en, mask_en;

  always_comb begin
    rsel = RSEL_NONE;
    if      (addr_i == ADDR_W'(OFS_PEND))  rsel = RSEL_PEND;
    else if (addr_i == ADDR_W'(OFS_FORCE)) rsel = RSEL_FORCE;
    else if (addr_i == ADDR_W'(OFS_CLEAR)) rsel = RSEL_CLEAR;
    else if (addr_i == ADDR_W'(OFS_MASK))  rsel = RSEL_MASK;
  end

  generate
    if (DATA_W > N) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:N];
    end
  endgenerate

  assign wdata_n      = wdata_i[N-1:0] & LINE_MASK;
  assign set_vec      = rise_i & LINE_MASK;
  assign clr_wr_vec   = (sel_i && wr_i && rsel == RSEL_CLEAR) ? wdata_n : '0;
  assign ack_vec      = ack_valid_i ? ((N'(1) << ack_id_i) & LINE_MASK) : '0;
  assign ack_to_force = ack_vec & force_q;
  assign ack_to_pend  = ack_vec & ~force_q;

  // next-state logic
  always_comb begin
    pend_en  = (|set_vec) || (|clr_wr_vec) || (|ack_to_pend);
    pend_d   = (pend_q & ~(clr_wr_vec | ack_to_pend)) | set_vec;
    force_en = (sel_i && wr_i && rsel == RSEL_FORCE) || (|ack_to_force);
    force_d  = (sel_i && wr_i && rsel == RSEL_FORCE) ? wdata_n
                                                     : (force_q & ~ack_to_force);
    mask_en  = sel_i && wr_i && rsel == RSEL_MASK;
    mask_d   = wdata_n;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      force_q <= '0;
      mask_q  <= '0;
    end else begin
      if (pend_en)  pend_q  <= pend_d;
      if (force_en) force_q <= force_d;
      if (mask_en)  mask_q  <= mask_d;
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_PEND:  rdata_o = DATA_W'(pend_q);
      RSEL_FORCE: rdata_o = DATA_W'(force_q);
      RSEL_MASK:  rdata_o = DATA_W'(mask_q);
      default:    rdata_o = '0;
    endcase
  end

  assign pend_o  = pend_q;
  assign force_o = force_q;
  assign mask_o  = mask_q;

  // R2: every captured edge is present in pending on the next cycle
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R3: cleared bits with no concurrent edge are gone on the next cycle
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(clr_wr_vec & ~set_vec)) |=> ((pend_q & $past(clr_wr_vec & ~set_vec)) == '0));

  // R4: a force write loads the written word
  a_r4_force_replace: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == ADDR_W'(OFS_FORCE))
      |=> (force_q == ($past(wdata_i[N-1:0]) & LINE_MASK)));

  // R7: acknowledging an unforced line clears its pending bit
  a_r7_ack_pending: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_valid_i && !force_q[ack_id_i] && !rise_i[ack_id_i])
      |=> !pend_q[$past(ack_id_i)]);
endmodule

// File: rtl/irq_force_ctl.sv
`timescale 1ns/1ps
module irq_force_ctl #(
  parameter int N      = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int ID_W   = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_id,
  output logic              irq_req,
  output logic [ID_W-1:0]   irq_id
);
  logic         rst_s1_q, rst_s2_q, rst_ni;
  logic [N-1:0] rise, pend, frc, msk, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ni = rst_s2_q;

  ictl_edge #(.N(N)) u_edge (
    .clk(clk), .rst_ni(rst_ni), .lines_i(irq_in), .rise_o(rise)
  );

  ictl_regs #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .rise_i(rise),
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .ack_valid_i(ack_valid), .ack_id_i(ack_id),
    .pend_o(pend), .force_o(frc), .mask_o(msk)
  );

  assign active = (pend | frc) & msk;

  ictl_prio #(.N(N), .ID_W(ID_W)) u_prio (
    .active_i(active), .req_o(irq_req), .id_o(irq_id)
  );

  // R6: reported line is active and no higher line is
  a_r6_id_highest: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_req |-> ((active >> irq_id) == N'(1)));

  // R6: no request means line number 0
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    !irq_req |-> (irq_id == '0));
endmodule

// File: tb/irq_force_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_force_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ack_valid;
  logic [3:0]  ack_id;
  logic        irq_req;
  logic [3:0]  irq_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_force_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic drive_lines(input logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [3:0] n);
    @(negedge clk);
    ack_valid = 1'b1; ack_id = n;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic chk_out(input string tag, input logic r, input logic [3:0] id);
    chk({tag, " req"}, 32'(irq_req), 32'(r));
    chk({tag, " id"}, 32'(irq_id), 32'(id));
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] m;
    rst_n = 1'b0; irq_in = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0;
    bus_wdata = '0; ack_valid = 0; ack_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_out("R1 reset", 1'b0, 4'd0);
    rd(8'h04, d); chk("R1 pending", d, 32'h0);
    rd(8'h08, d); chk("R1 force", d, 32'h0);
    rd(8'h40, d); chk("R1 mask", d, 32'h0);

    // R5 / R8: mask write drops bit 0, unmapped offsets read 0
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R5 mask readback", d, 32'h0000_FFFE);
    rd(8'h00, d); chk("R8 offset 0x00", d, 32'h0);
    rd(8'h0C, d); chk("R8 offset 0x0C", d, 32'h0);
    rd(8'h10, d); chk("R8 offset 0x10", d, 32'h0);

    // R2 / R3 per-line sweep
    for (int n = 1; n < 16; n++) begin
      drive_lines(16'(1) << n);
      rd(8'h04, d); chk($sformatf("R2 edge line %0d", n), d, 32'(1) << n);
      chk_out($sformatf("R6 single line %0d", n), 1'b1, 4'(n));
      wr(8'h0C, 32'(1) << n);
      rd(8'h04, d); chk($sformatf("R3 clear line %0d", n), d, 32'h0);
      @(negedge clk);
      rd(8'h04, d); chk($sformatf("R2 held high line %0d", n), d, 32'h0);
      drive_lines('0);
    end
    drive_lines(16'h0001);
    rd(8'h04, d); chk("R2 line 0 ignored", d, 32'h0);
    chk_out("R2 line 0 no request", 1'b0, 4'd0);
    drive_lines('0);

    // R5 mask window sweep over a full pending set
    drive_lines(16'hFFFE);
    drive_lines('0);
    for (int n = 1; n < 16; n++) begin
      m = 16'((32'(1) << (n + 1)) - 1) & 16'hFFFE;
      wr(8'h40, 32'(m));
      chk_out($sformatf("R5 window up to %0d", n), 1'b1, 4'(n));
    end
    wr(8'h40, 32'h0);
    chk_out("R5 all masked", 1'b0, 4'd0);
    rd(8'h04, d); chk("R5 pending kept", d, 32'h0000_FFFE);
    wr(8'h40, 32'hFFFF);

    // R3 partial clear
    wr(8'h0C, 32'h0000_5550);
    rd(8'h04, d); chk("R3 partial clear", d, 32'h0000_AAAE);
    wr(8'h0C, 32'hFFFF);
    rd(8'h04, d); chk("R3 clear all", d, 32'h0);

    // R9 edge and clear in the same cycle
    @(negedge clk);
    irq_in = 16'h0080;
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h0080;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rd(8'h04, d); chk("R9 set wins", d, 32'h0000_0080);
    drive_lines('0);
    wr(8'h0C, 32'hFFFF);

    // R4 / R6 forced pairs
    for (int a = 1; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        wr(8'h08, (32'(1) << a) | (32'(1) << b));
        chk_out($sformatf("R6 pair %0d,%0d", a, b), 1'b1, 4'(b));
        wr(8'h08, 32'(1) << a);
        chk_out($sformatf("R4 replace to %0d", a), 1'b1, 4'(a));
      end
    end
    wr(8'h08, 32'h0000_0001);
    rd(8'h08, d); chk("R4 bit 0 dropped", d, 32'h0);
    chk_out("R4 force removed", 1'b0, 4'd0);

    // R7 acknowledge
    drive_lines(16'h0020);
    drive_lines('0);
    ack(4'd5);
    rd(8'h04, d); chk("R7 ack pending", d, 32'h0);
    wr(8'h08, 32'h0200);
    ack(4'd9);
    rd(8'h08, d); chk("R7 ack forced", d, 32'h0);
    chk_out("R7 forced line gone", 1'b0, 4'd0);
    drive_lines(16'h0008);
    drive_lines('0);
    wr(8'h08, 32'h0008);
    ack(4'd3);
    rd(8'h08, d); chk("R7 ack both: force", d, 32'h0);
    rd(8'h04, d); chk("R7 ack both: pending kept", d, 32'h0000_0008);
    chk_out("R7 ack both: still requested", 1'b1, 4'd3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule